// File: doc/BRIEF.md
# Threshold-Driven FIFO with DMA Request Routing

This block holds a 32-word by 16-bit buffer between a host register port and a card-side data engine. In a receive transfer the card engine fills the buffer through a valid/ready stream and the host empties it by reading the data register. In a transmit transfer the host fills the buffer by writing the data register and the card engine drains it through a second valid/ready stream. When no transfer is running, the host both fills and empties the buffer.

After every buffer change the block compares occupancy with two programmable levels. On the receive side the level is a high-water mark. On the transmit side it is a low-water mark. A per-direction DMA enable bit in the buffer configuration register decides where a crossing goes. With DMA enabled it raises a DMA request line. With DMA disabled it sets a status flag instead. The status register is cleared by writing ones, and it drives a level interrupt through an enable mask. The command path elsewhere sets the other status bits through a set-pulse input.

Back-pressure rules: the receive stream's `card_rx_ready` is high only while a receive transfer is active and fewer than 32 words are held. A word moves when `card_rx_valid` and `card_rx_ready` are both high at a clock edge. The transmit stream's `card_tx_valid` is high only while a transmit transfer is active and the buffer is not empty. `card_tx_data` is the oldest word, and it moves when `card_tx_ready` is high at an edge. A data-register write is one host push and a data-register read is one host pop. `reg_rdata` is combinational from `reg_addr`, whether or not `reg_rd` is high.

Top module: `fifo_thresh_dma`

## Requirements
- R1: After reset the status and interrupt mask read 0, the buffer configuration reads 0x1F00 (high-water 31, low-water 0, both DMA enables off), and `rx_dma_req`, `tx_dma_req`, `irq`, `card_rx_ready` and `card_tx_valid` are low.
- R2: Words leave the buffer in the order they arrived, whether they leave by host reads of the data register or by the transmit stream.
- R3: Routing depends on the transfer.
  - While a receive transfer is active (`xfer_active`=1, `xfer_dir`=1), only the receive stream pushes, and host data writes are ignored.
  - While a transmit transfer is active (`xfer_active`=1, `xfer_dir`=0), only the transmit stream pops, and host data reads do not pop.
  - Otherwise the host pushes and pops.
- R4: A host data write while 32 words are held is dropped, and `card_rx_ready` is low while 32 words are held.
- R5: A host data read of an empty buffer returns the word stored at the read position and moves no pointer. `card_tx_valid` is low while the buffer is empty.
- R6: Receive-side evaluation:
  - With `xfer_dir`=1 and occupancy greater than the high-water level, `rx_dma_req` is asserted if receive DMA is enabled; otherwise status bit 10 is set.
  - In every other case both are cleared.
- R7: Transmit-side evaluation:
  - With `xfer_dir`=0 and occupancy less than the low-water level, `tx_dma_req` is asserted if transmit DMA is enabled; otherwise status bit 11 is set.
  - In every other case both are cleared.
- R8: When evaluation finds no active transfer and an empty buffer, status bits 10 and 11 and both request lines are cleared.
- R9: Evaluation timing:
  - Evaluation takes effect at the clock edge after the edge of a push, a pop, a configuration write, or a change of `xfer_active`.
  - At no other time do bits 10 and 11 or the request lines change, except through R10 and R12.
- R10: A status write clears exactly the bits written as 1. An `evt_set` bit sets the matching status bit, except for bits 10 and 11, which `evt_set` cannot touch.
- R11: `irq` equals the OR of (status AND interrupt mask).
- R12: A configuration write with receive DMA enabled clears status bit 10, and one with transmit DMA enabled clears status bit 11, at the edge of the write itself.
- R13: Buffer configuration fields:
  - Bit 15 is the receive DMA enable, bits 12:8 the high-water level, bit 7 the transmit DMA enable, and bits 4:0 the low-water level.
  - Other bits read as 0.
  - Register selects on `reg_addr`: 0 data, 1 status, 2 interrupt mask, 3 buffer configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (pops only for the data register) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data, combinational from `reg_addr` |
| xfer_active | input | 1 | A data transfer is in progress |
| xfer_dir | input | 1 | 1 = card to host, 0 = host to card |
| card_rx_valid | input | 1 | Receive stream word valid |
| card_rx_ready | output | 1 | Buffer can accept a receive word |
| card_rx_data | input | 16 | Receive stream word |
| card_tx_valid | output | 1 | Transmit stream word available |
| card_tx_ready | input | 1 | Card engine takes the transmit word |
| card_tx_data | output | 16 | Oldest buffered word |
| evt_set | input | 16 | Set pulses for status bits other than 10 and 11 |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situations to reach are the threshold boundaries at both ends of the buffer. These are occupancy equal to the level, one either side of it, a full buffer, and the empty-while-active versus empty-while-idle distinction. Each requires the buffer to be walked word by word to an exact fill.

The bench therefore sweeps occupancy over every value from 0 to 32 and back, one push or pop at a time. It does this for several low-water and high-water levels, including 0 and 31, and with each DMA enable both on and off. After every step it compares the flags and request lines with the rule computed from the count it tracks itself.

The single-cycle evaluation lag is observed by holding the status select on the read port right after a push. A status clear that sticks until the next buffer event is observed by waiting several idle cycles after the write.

// File: rtl/fifo_thresh_pkg.sv
package fifo_thresh_pkg;

  typedef enum logic [1:0] {
    REG_DATA   = 2'd0,
    REG_STAT   = 2'd1,
    REG_MASK   = 2'd2,
    REG_BUFCFG = 2'd3
  } reg_sel_e;

  // status bit positions owned by the threshold logic
  localparam int STAT_RX_BIT = 10;
  localparam int STAT_TX_BIT = 11;

  // buffer configuration field positions
  localparam int CFG_RXDMA_BIT = 15;
  localparam int CFG_HI_LSB    = 8;
  localparam int CFG_TXDMA_BIT = 7;
  localparam int CFG_LO_LSB    = 0;

endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int DEPTH = 32,
  parameter int W     = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [W-1:0]             push_data,
  input  logic                     pop,
  output logic [W-1:0]             head,
  output logic [$clog2(DEPTH):0]   occ
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] cnt;
  logic [AW-1:0] wr_idx;

  // write position wraps with the pointer width (DEPTH is a power of two)
  assign wr_idx = rd_ptr + cnt[AW-1:0];

  always_ff @(posedge clk) begin
    if (push) mem[wr_idx] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (pop) rd_ptr <= rd_ptr + AW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign head = mem[rd_ptr];
  assign occ  = cnt;
endmodule

// File: rtl/thresh_eval.sv
module thresh_eval #(
  parameter int DEPTH = 32
) (
  input  logic [$clog2(DEPTH):0]   occ,
  input  logic [$clog2(DEPTH)-1:0] hi_lvl,
  input  logic [$clog2(DEPTH)-1:0] lo_lvl,
  input  logic                     rx_dma_en,
  input  logic                     tx_dma_en,
  input  logic                     xfer_active,
  input  logic                     xfer_dir,
  output logic                     rx_flag_n,
  output logic                     tx_flag_n,
  output logic                     rx_req_n,
  output logic                     tx_req_n
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic idle, rx_hit, tx_hit;
  logic [1:0] hit, dma, flag_v, req_v;

  always_comb begin
    idle   = !xfer_active && (occ == '0);
    rx_hit = !idle &&  xfer_dir && (occ > CW'(hi_lvl));
    tx_hit = !idle && !xfer_dir && (occ < CW'(lo_lvl));
    hit    = {tx_hit, rx_hit};
    dma    = {tx_dma_en, rx_dma_en};
  end

  // the same routing applies per direction: DMA line or status flag
  for (genvar d = 0; d < 2; d++) begin : g_route
    assign req_v[d]  = hit[d] &&  dma[d];
    assign flag_v[d] = hit[d] && !dma[d];
  end

  assign rx_req_n  = req_v[0];
  assign tx_req_n  = req_v[1];
  assign rx_flag_n = flag_v[0];
  assign tx_flag_n = flag_v[1];
endmodule

// File: rtl/stat_ctrl.sv
module stat_ctrl
  import fifo_thresh_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_evt,
  input  logic          cfg_wr,
  input  logic          cfg_rx_dma,
  input  logic          cfg_tx_dma,
  input  logic          xfer_active,
  input  logic          stat_wr,
  input  logic          mask_wr,
  input  logic [SW-1:0] wdata,
  input  logic [SW-1:0] evt_set,
  input  logic          rx_flag_n,
  input  logic          tx_flag_n,
  input  logic          rx_req_n,
  input  logic          tx_req_n,
  output logic [SW-1:0] status,
  output logic [SW-1:0] mask,
  output logic          rx_req,
  output logic          tx_req,
  output logic          eval_pend,
  output logic          irq
);
  localparam logic [SW-1:0] THR_BITS =
    (SW'(1) << STAT_RX_BIT) | (SW'(1) << STAT_TX_BIT);

  logic          act_q;
  logic [SW-1:0] stat_nxt;

  always_comb begin
    stat_nxt = status;
    if (eval_pend) begin
      stat_nxt[STAT_RX_BIT] = rx_flag_n;
      stat_nxt[STAT_TX_BIT] = tx_flag_n;
    end
    if (stat_wr) stat_nxt = stat_nxt & ~wdata;
    stat_nxt = stat_nxt | (evt_set & ~THR_BITS);
    if (cfg_wr && cfg_rx_dma) stat_nxt[STAT_RX_BIT] = 1'b0;
    if (cfg_wr && cfg_tx_dma) stat_nxt[STAT_TX_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status    <= '0;
      mask      <= '0;
      rx_req    <= 1'b0;
      tx_req    <= 1'b0;
      eval_pend <= 1'b0;
      act_q     <= 1'b0;
    end else begin
      status    <= stat_nxt;
      act_q     <= xfer_active;
      eval_pend <= fifo_evt || cfg_wr || (xfer_active != act_q);
      if (mask_wr) mask <= wdata;
      if (eval_pend) begin
        rx_req <= rx_req_n;
        tx_req <= tx_req_n;
      end
    end
  end

  assign irq = |(status & mask);
endmodule

// File: rtl/fifo_thresh_dma.sv
module fifo_thresh_dma
  import fifo_thresh_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         xfer_active,
  input  logic         xfer_dir,
  input  logic         card_rx_valid,
  output logic         card_rx_ready,
  input  logic [W-1:0] card_rx_data,
  output logic         card_tx_valid,
  input  logic         card_tx_ready,
  output logic [W-1:0] card_tx_data,
  input  logic [W-1:0] evt_set,
  output logic         rx_dma_req,
  output logic         tx_dma_req,
  output logic         irq
);
  localparam int LW = $clog2(DEPTH);
  localparam int CW = LW + 1;

  reg_sel_e      sel;
  logic          rx_mode, tx_mode;
  logic          host_push, host_pop, card_push, card_pop;
  logic          push, pop;
  logic [W-1:0]  push_data, head;
  logic [CW-1:0] occ;
  logic          cfg_wr, stat_wr, mask_wr;
  logic          cfg_rx_dma, cfg_tx_dma;
  logic [LW-1:0] cfg_hi, cfg_lo;
  logic          rx_flag_n, tx_flag_n, rx_req_n, tx_req_n;
  logic [W-1:0]  stat_q, mask_q, cfg_view;
  logic          eval_pend;

  assign sel     = reg_sel_e'(reg_addr);
  assign rx_mode = xfer_active &&  xfer_dir;
  assign tx_mode = xfer_active && !xfer_dir;

  // push and pop source selection
  assign card_rx_ready = rx_mode && (occ < CW'(DEPTH));
  assign card_push     = card_rx_valid && card_rx_ready;
  assign host_push     = reg_wr && (sel == REG_DATA) && !rx_mode && (occ < CW'(DEPTH));
  assign push          = card_push || host_push;
  assign push_data     = rx_mode ? card_rx_data : reg_wdata;

  assign card_tx_valid = tx_mode && (occ != '0);
  assign card_pop      = card_tx_valid && card_tx_ready;
  assign host_pop      = reg_rd && (sel == REG_DATA) && !tx_mode && (occ != '0);
  assign pop           = card_pop || host_pop;
  assign card_tx_data  = head;

  assign cfg_wr  = reg_wr && (sel == REG_BUFCFG);
  assign stat_wr = reg_wr && (sel == REG_STAT);
  assign mask_wr = reg_wr && (sel == REG_MASK);

  fifo_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_data(push_data),
    .pop(pop), .head(head), .occ(occ)
  );

  // buffer configuration register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rx_dma <= 1'b0;
      cfg_tx_dma <= 1'b0;
      cfg_hi     <= '1;
      cfg_lo     <= '0;
    end else if (cfg_wr) begin
      cfg_rx_dma <= reg_wdata[CFG_RXDMA_BIT];
      cfg_tx_dma <= reg_wdata[CFG_TXDMA_BIT];
      cfg_hi     <= reg_wdata[CFG_HI_LSB +: LW];
      cfg_lo     <= reg_wdata[CFG_LO_LSB +: LW];
    end
  end

  always_comb begin
    cfg_view = '0;
    cfg_view[CFG_RXDMA_BIT]    = cfg_rx_dma;
    cfg_view[CFG_TXDMA_BIT]    = cfg_tx_dma;
    cfg_view[CFG_HI_LSB +: LW] = cfg_hi;
    cfg_view[CFG_LO_LSB +: LW] = cfg_lo;
  end

  thresh_eval #(.DEPTH(DEPTH)) u_eval (
    .occ(occ), .hi_lvl(cfg_hi), .lo_lvl(cfg_lo),
    .rx_dma_en(cfg_rx_dma), .tx_dma_en(cfg_tx_dma),
    .xfer_active(xfer_active), .xfer_dir(xfer_dir),
    .rx_flag_n(rx_flag_n), .tx_flag_n(tx_flag_n),
    .rx_req_n(rx_req_n), .tx_req_n(tx_req_n)
  );

  stat_ctrl #(.SW(W)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .fifo_evt(push || pop), .cfg_wr(cfg_wr),
    .cfg_rx_dma(reg_wdata[CFG_RXDMA_BIT]), .cfg_tx_dma(reg_wdata[CFG_TXDMA_BIT]),
    .xfer_active(xfer_active),
    .stat_wr(stat_wr), .mask_wr(mask_wr), .wdata(reg_wdata), .evt_set(evt_set),
    .rx_flag_n(rx_flag_n), .tx_flag_n(tx_flag_n),
    .rx_req_n(rx_req_n), .tx_req_n(tx_req_n),
    .status(stat_q), .mask(mask_q),
    .rx_req(rx_dma_req), .tx_req(tx_dma_req),
    .eval_pend(eval_pend), .irq(irq)
  );

  always_comb begin
    unique case (sel)
      REG_DATA:   reg_rdata = head;
      REG_STAT:   reg_rdata = stat_q;
      REG_MASK:   reg_rdata = mask_q;
      REG_BUFCFG: reg_rdata = cfg_view;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fifo_thresh_dma_chk.sv
module fifo_thresh_dma_chk
  import fifo_thresh_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int W     = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [$clog2(DEPTH):0] occ,
  input logic                   card_rx_ready,
  input logic                   card_tx_valid,
  input logic                   rx_dma_req,
  input logic                   tx_dma_req,
  input logic [W-1:0]           stat_q,
  input logic                   cfg_wr,
  input logic [W-1:0]           reg_wdata,
  input logic                   eval_pend,
  input logic                   xfer_active
);
  localparam int CW = $clog2(DEPTH) + 1;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH)); // R4
  AST_FULL_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CW'(DEPTH)) |-> !card_rx_ready); // R4
  AST_EMPTY_NO_TXVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !card_tx_valid); // R5
  AST_RX_REQ_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |-> !stat_q[STAT_RX_BIT]); // R6
  AST_TX_REQ_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req |-> !stat_q[STAT_TX_BIT]); // R7
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_pend && !xfer_active && occ == '0) |=>
      (!stat_q[STAT_RX_BIT] && !stat_q[STAT_TX_BIT] && !rx_dma_req && !tx_dma_req)); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_pend |=> ($stable(rx_dma_req) && $stable(tx_dma_req))); // R9
  AST_RX_DMA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && reg_wdata[CFG_RXDMA_BIT]) |=> !stat_q[STAT_RX_BIT]); // R12
  AST_TX_DMA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && reg_wdata[CFG_TXDMA_BIT]) |=> !stat_q[STAT_TX_BIT]); // R12
endmodule

bind fifo_thresh_dma fifo_thresh_dma_chk #(.DEPTH(DEPTH), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .occ(occ),
  .card_rx_ready(card_rx_ready), .card_tx_valid(card_tx_valid),
  .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
  .stat_q(stat_q), .cfg_wr(cfg_wr), .reg_wdata(reg_wdata),
  .eval_pend(eval_pend), .xfer_active(xfer_active)
);

// File: tb/tb_fifo_thresh_dma.sv
`timescale 1ns/1ps
module tb_fifo_thresh_dma;
  localparam logic [1:0] A_DATA = 2'd0, A_STAT = 2'd1, A_MASK = 2'd2, A_CFG = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = A_STAT;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        xfer_active = 1'b0, xfer_dir = 1'b0;
  logic        card_rx_valid = 1'b0;
  logic        card_rx_ready;
  logic [15:0] card_rx_data = '0;
  logic        card_tx_valid;
  logic        card_tx_ready = 1'b0;
  logic [15:0] card_tx_data;
  logic [15:0] evt_set = '0;
  logic        rx_dma_req, tx_dma_req, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fifo_thresh_dma dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xfer_active(xfer_active), .xfer_dir(xfer_dir),
    .card_rx_valid(card_rx_valid), .card_rx_ready(card_rx_ready),
    .card_rx_data(card_rx_data), .card_tx_valid(card_tx_valid),
    .card_tx_ready(card_tx_ready), .card_tx_data(card_tx_data),
    .evt_set(evt_set), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
    .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic hrd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic cpush(logic [15:0] d, string tag);
    @(negedge clk);
    card_rx_valid = 1'b1; card_rx_data = d;
    #1 check(tag, card_rx_ready, 1);
    @(negedge clk);
    card_rx_valid = 1'b0;
  endtask

  // one cycle for evaluation, then flags {bit11, bit10, tx_req, rx_req}
  task automatic chk_flags(string tag, bit rxf, bit txf, bit rxq, bit txq);
    logic [15:0] s;
    logic [1:0]  q;
    @(negedge clk);
    q = {tx_dma_req, rx_dma_req};
    hrd(A_STAT, s);
    check(tag, {s[11], s[10], q}, {txf, rxf, txq, rxq});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int lo_list[5] = '{0, 1, 5, 17, 31};
    int hi_list[5] = '{0, 3, 16, 30, 31};
    int base;
    int cnt;
    bit hit;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pins", {rx_dma_req, tx_dma_req, irq, card_rx_ready, card_tx_valid}, 0);
    hrd(A_STAT, d);   check("R1 status", d, 16'h0000);
    hrd(A_MASK, d);   check("R1 mask", d, 16'h0000);
    hrd(A_CFG, d);    check("R1 bufcfg", d, 16'h1F00);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 field layout
    hwr(A_CFG, 16'hFFFF); hrd(A_CFG, d); check("R13 readback all ones", d, 16'h9F9F);
    hwr(A_CFG, 16'h0000); hrd(A_CFG, d); check("R13 readback zero", d, 16'h0000);
    repeat (2) @(negedge clk);

    // transmit-side sweep, host fills and empties (no transfer active)
    xfer_active = 1'b0; xfer_dir = 1'b0;
    base = 0;
    foreach (lo_list[i]) begin
      for (int dma = 0; dma < 2; dma++) begin
        base += 64;
        hwr(A_CFG, 16'((dma << 7) | lo_list[i]));
        chk_flags("R8 idle after cfg", 0, 0, 0, 0);
        for (int k = 1; k <= 32; k++) begin
          hwr(A_DATA, 16'(base + k));
          hit = (k < lo_list[i]);
          chk_flags("R7 fill", 0, hit && dma == 0, 0, hit && dma == 1);
        end
        hwr(A_DATA, 16'hDEAD);   // R4 dropped when full
        for (int k = 1; k <= 32; k++) begin
          hrd(A_DATA, d);
          check("R2 host order", d, 16'(base + k));
          cnt = 32 - k;
          hit = (cnt != 0) && (cnt < lo_list[i]);
          chk_flags("R7/R8 drain", 0, hit && dma == 0, 0, hit && dma == 1);
        end
        hrd(A_DATA, d);
        check("R4/R5 empty read at read position", d, 16'(base + 1));
        check("R5 no tx valid", card_tx_valid, 0);
      end
    end

    // R5 empty read leaves pointers: next write lands at the same slot
    hwr(A_DATA, 16'h5A5A);
    hrd(A_DATA, d); check("R5 pointer unchanged", d, 16'h5A5A);

    // receive-side sweep, card fills through the stream
    xfer_active = 1'b1; xfer_dir = 1'b1;
    foreach (hi_list[i]) begin
      for (int dma = 0; dma < 2; dma++) begin
        base += 64;
        hwr(A_CFG, 16'((dma << 15) | (hi_list[i] << 8)));
        chk_flags("R6 empty active", 0, 0, 0, 0);
        for (int k = 1; k <= 32; k++) begin
          cpush(16'(base + k), "R4 ready below full");
          hit = (k > hi_list[i]);
          chk_flags("R6 fill", hit && dma == 0, 0, hit && dma == 1, 0);
        end
        @(negedge clk); #1 check("R4 ready low when full", card_rx_ready, 0);
        for (int k = 1; k <= 32; k++) begin
          hrd(A_DATA, d);
          check("R2 rx order", d, 16'(base + k));
          cnt = 32 - k;
          hit = (cnt > hi_list[i]);
          chk_flags("R6 drain", hit && dma == 0, 0, hit && dma == 1, 0);
        end
      end
    end

    // R3 host data write ignored during receive transfer
    hwr(A_CFG, 16'h1F00);
    hwr(A_DATA, 16'hBEEF);
    cpush(16'h1111, "R3 ready");
    hrd(A_DATA, d); check("R3 host write ignored in rx", d, 16'h1111);

    // R2/R3 transmit stream drains, host reads do not pop
    xfer_active = 1'b0; xfer_dir = 1'b0;
    hwr(A_CFG, 16'h0000);
    for (int k = 0; k < 5; k++) hwr(A_DATA, 16'(16'h2000 + k));
    xfer_active = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      #1 check("R2 tx stream valid", card_tx_valid, 1);
      check("R2 tx stream order", card_tx_data, 16'(16'h2000 + k));
      if (k == 1) begin
        hrd(A_DATA, d); check("R3 host read sees head", d, 16'h2001);
        @(negedge clk); #1 check("R3 host read did not pop", card_tx_data, 16'h2001);
      end
      card_tx_ready = 1'b1;
      @(negedge clk);
      card_tx_ready = 1'b0;
    end
    #1 check("R5 tx valid low when empty", card_tx_valid, 0);
    xfer_active = 1'b0;
    repeat (3) @(negedge clk);

    // R9 lag, R10 W1C, R11 irq
    hwr(A_CFG, 16'h0005);
    repeat (2) @(negedge clk);
    hwr(A_DATA, 16'h3000);
    reg_addr = A_STAT;
    #1 check("R9 not yet evaluated", reg_rdata[11], 0);
    @(negedge clk); #1 check("R9 evaluated one cycle later", reg_rdata[11], 1);
    hwr(A_MASK, 16'h0800); #1 check("R11 irq on", irq, 1);
    hwr(A_MASK, 16'h0400); #1 check("R11 irq masked", irq, 0);
    hwr(A_MASK, 16'h0800);
    hwr(A_STAT, 16'hF7FF); hrd(A_STAT, d); check("R10 other ones keep bit", d, 16'h0800);
    hwr(A_STAT, 16'h0800); hrd(A_STAT, d); check("R10 cleared", d, 16'h0000);
    check("R11 irq off", irq, 0);
    repeat (4) @(negedge clk);
    hrd(A_STAT, d); check("R9 stays clear without event", d, 16'h0000);
    @(negedge clk); evt_set = 16'h0C03;
    @(negedge clk); evt_set = 16'h0000;
    hrd(A_STAT, d); check("R10 set pulses skip 10/11", d, 16'h0003);
    hwr(A_MASK, 16'h0001); #1 check("R11 irq from set bit", irq, 1);
    hwr(A_STAT, 16'h0001); hrd(A_STAT, d); check("R10 partial clear", d, 16'h0002);
    check("R11 irq after clear", irq, 0);
    hwr(A_STAT, 16'hFFFF);

    // R12 dma enable clears flag at its own edge
    hwr(A_DATA, 16'h3001);
    chk_flags("R7 flag set at 2 words", 0, 1, 0, 0);
    hwr(A_CFG, 16'h0085);
    reg_addr = A_STAT;
    #1 check("R12 flag cleared by enable", reg_rdata[11], 0);
    @(negedge clk); #1 check("R12 request after reevaluation", tx_dma_req, 1);
    hrd(A_DATA, d); check("R2 order", d, 16'h3000);
    hrd(A_DATA, d); check("R2 order", d, 16'h3001);
    chk_flags("R8 idle clears request", 0, 0, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule